// File: doc/BRIEF.md
# Half-Band Interpolate-by-Two Stage

This block doubles the sample rate of a signed two's-complement stream. It
behaves as an ideal zero-stuffing upsampler followed by an 11-tap linear-phase
half-band lowpass that removes the spectral image. The filter is split into two
polyphase branches that both run at the input rate, so no arithmetic is ever
spent on the inserted zeros.

The stage gain is two. With that gain the centre tap becomes exactly one, so
one branch is only a delay. The other branch holds three distinct symmetric
coefficients. Mirrored delay-line samples are summed first, and each sum is then
multiplied by a fixed constant built from shifts, additions and subtractions. A
pipeline register sits between the pre-adders and the constant-multiply adder
tree. A commutator emits the filtered branch result and then the delayed centre
sample, so every accepted input gives two outputs on consecutive cycles. Inputs
are taken with a valid/ready handshake, at most one in every two cycles. The
output is a strobe that can be high on every cycle.

Top module: `halfband_interp2`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and in_ready is 1 until the first sample is accepted. The filter history is cleared to zero, so the first outputs are computed as if all earlier inputs were zero.
- R2: A sample accepted at clock edge k produces out_valid high on the cycles after edges k+2 and k+3, in that order. It produces no other output.
- R3: The first output of each pair is y = 7*(x0+x5) - 29*(x1+x4) + 150*(x2+x3), divided by 256. Here x0 is the newest accepted sample and x5 the one accepted five samples earlier.
- R4: The second output of each pair equals, unchanged, the sample accepted two samples before the newest one (x2).
- R5: in_ready is low on the cycle after every acceptance and high otherwise. While in_ready is low, in_valid and in_data have no effect.
- R6: The division by 256 in R3 rounds half upward: 128 is added, then the result is shifted right arithmetically by 8.
- R7: The rounded first output is clamped to the range -2^(DATA_W-1) to 2^(DATA_W-1)-1. Intermediate sums never wrap.
- R8: The output sequence equals zero-stuffing by two followed by convolution with h = [7,0,-29,0,150,256,150,0,-29,0,7]/256, then rounding (R6) and clamping (R7). This holds for any pattern of input gaps, including back-to-back input at the maximum rate, where out_valid stays high continuously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Stage can take a sample this cycle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Signed output sample |

## Verification
Two things can fall on the same clock edge: accepting a new sample, which
shifts the delay line, and emitting the delayed-branch sample of the previous
input. The commutator's own hold register has to supply that delayed sample,
not the delay line that is shifting under it. This case is provoked by pushing
samples back to back at the maximum rate. The emitted stream is then compared
with a zero-stuff-and-convolve reference computed in the bench. A second
collision is an offered sample while in_ready is low. It is provoked by holding
in_valid high with different data through the blocked cycle. It is judged by
the full output sequence matching a reference that never saw that data.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int ACC_W     = 40;
  localparam int FRAC_BITS = 8;
  localparam int HALF_TAPS = 3;

  typedef logic signed [ACC_W-1:0] acc_t;

  // 150 * p, built from shifts and adds
  function automatic acc_t k_inner(acc_t p);
    return (p <<< 7) + (p <<< 4) + (p <<< 2) + (p <<< 1);
  endfunction

  // 29 * p
  function automatic acc_t k_mid(acc_t p);
    return (p <<< 5) - (p <<< 1) - p;
  endfunction

  // 7 * p
  function automatic acc_t k_outer(acc_t p);
    return (p <<< 3) - p;
  endfunction

  // filtered polyphase branch: +150, -29, +7 applied to the pre-added pairs
  function automatic acc_t branch_sum(acc_t p_inner, acc_t p_mid, acc_t p_outer);
    return k_inner(p_inner) - k_mid(p_mid) + k_outer(p_outer);
  endfunction

  // round half up at frac bits, then clamp to a w-bit signed range
  function automatic acc_t round_sat(acc_t a, int frac, int w);
    acc_t half;
    acc_t r;
    acc_t hi;
    acc_t lo;
    half = acc_t'(1) <<< (frac - 1);
    r    = (a + half) >>> frac;
    hi   = (acc_t'(1) <<< (w - 1)) - acc_t'(1);
    lo   = -(acc_t'(1) <<< (w - 1));
    if (r > hi) return hi;
    if (r < lo) return lo;
    return r;
  endfunction
endpackage

// File: rtl/hbi_delay_line.sv
module hbi_delay_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     in_ready,
  output logic                     accept,
  output logic                     fresh,
  output logic signed [DATA_W-1:0] taps [DEPTH]
);
  logic busy_q;

  assign in_ready = ~busy_q;
  assign accept   = in_valid & in_ready;
  assign fresh    = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= accept;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
    end else if (accept) begin
      taps[0] <= in_data;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

  // R5: a blocked cycle leaves the history untouched
  a_r5_stall_keeps_taps: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (taps[0] == $past(taps[0])) && (taps[DEPTH-1] == $past(taps[DEPTH-1])));
endmodule

// File: rtl/hbi_preadd.sv
module hbi_preadd #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fresh,
  input  logic signed [DATA_W-1:0] taps [DEPTH],
  output logic                     s1_valid,
  output logic signed [DATA_W:0]   pre [DEPTH/2],
  output logic signed [DATA_W-1:0] centre
);
  localparam int HALF = DEPTH / 2;

  logic signed [DATA_W:0] pair_sum [HALF];

  // mirrored samples share one coefficient, so add them first
  for (genvar gi = 0; gi < HALF; gi++) begin : g_pair
    assign pair_sum[gi] = {taps[gi][DATA_W-1], taps[gi]}
                        + {taps[DEPTH-1-gi][DATA_W-1], taps[DEPTH-1-gi]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      centre   <= '0;
      for (int i = 0; i < HALF; i++) pre[i] <= '0;
    end else begin
      s1_valid <= fresh;
      if (fresh) begin
        centre <= taps[HALF-1];
        for (int i = 0; i < HALF; i++) pre[i] <= pair_sum[i];
      end
    end
  end
endmodule

// File: rtl/hbi_commutator.sv
module hbi_commutator
  import hbi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HALF   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_valid,
  input  logic signed [DATA_W:0]   pre [HALF],
  input  logic signed [DATA_W-1:0] centre,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     even_emit,
  output logic                     odd_emit
);
  logic                     odd_pend;
  logic signed [DATA_W-1:0] odd_hold;
  acc_t                     filt_acc;
  acc_t                     filt_out;

  assign filt_acc  = branch_sum(acc_t'(pre[HALF-1]), acc_t'(pre[1]), acc_t'(pre[0]));
  assign filt_out  = round_sat(filt_acc, FRAC_BITS, DATA_W);
  assign even_emit = s1_valid;
  assign odd_emit  = odd_pend & ~s1_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      odd_pend  <= 1'b0;
      odd_hold  <= '0;
    end else if (even_emit) begin
      out_valid <= 1'b1;
      out_data  <= filt_out[DATA_W-1:0];
      odd_hold  <= centre;
      odd_pend  <= 1'b1;
    end else if (odd_emit) begin
      out_valid <= 1'b1;
      out_data  <= odd_hold;
      odd_pend  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
    end
  end

  // R2: a filtered sample is always followed by its delayed-branch partner
  a_r2_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    even_emit |=> odd_emit && !even_emit);

  // R4: the delayed branch carries the centre sample without change
  a_r4_centre_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    odd_emit |=> out_valid && (out_data == $past(centre)));
endmodule

// File: rtl/halfband_interp2.sv
module halfband_interp2
  import hbi_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int DEPTH = 2 * HALF_TAPS;

  logic                     accept;
  logic                     fresh;
  logic                     s1_valid;
  logic                     even_emit;
  logic                     odd_emit;
  logic signed [DATA_W-1:0] taps [DEPTH];
  logic signed [DATA_W:0]   pre [HALF_TAPS];
  logic signed [DATA_W-1:0] centre;

  hbi_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_line (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .accept(accept), .fresh(fresh), .taps(taps));

  hbi_preadd #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_pre (
    .clk(clk), .rst_n(rst_n), .fresh(fresh), .taps(taps),
    .s1_valid(s1_valid), .pre(pre), .centre(centre));

  hbi_commutator #(.DATA_W(DATA_W), .HALF(HALF_TAPS)) u_comm (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .pre(pre), .centre(centre),
    .out_valid(out_valid), .out_data(out_data),
    .even_emit(even_emit), .odd_emit(odd_emit));

  // R2: two edges from acceptance to the filtered output being loaded
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 even_emit);

  // R5: acceptances are never on adjacent edges
  a_r5_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);
endmodule

// File: tb/test_halfband_interp2.sv
module test_halfband_interp2;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [15:0] in_data = '0;
  logic               out_valid;
  logic signed [15:0] out_data;

  always #10 clk = ~clk;

  halfband_interp2 #(.DATA_W(16)) i_halfband_interp2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // rows: input, expected first output, expected second output (from reset)
  localparam int TBL [18][3] = '{
    '{1024, 28, 0}, '{0, -116, 0}, '{0, 600, 1024}, '{0, 600, 0},
    '{0, -116, 0},  '{0, 28, 0},   '{128, 4, 0},    '{0, -14, 0},
    '{0, 75, 128},  '{0, 75, 0},   '{0, -14, 0},    '{0, 4, 0},
    '{-128, -3, 0}, '{0, 15, 0},   '{0, -75, -128}, '{0, -75, 0},
    '{0, 15, 0},    '{0, -3, 0}};

  localparam int H [11] = '{7, 0, -29, 0, 150, 256, 150, 0, -29, 0, 7};

  longint xs [512];
  int     nx = 0;
  longint expv [1024];
  int     ne = 0;
  logic signed [15:0] got [1024];
  int     ng = 0;

  function automatic longint ustuff(int j);
    if (j < 0 || (j % 2) != 0) return 0;
    return xs[j/2];
  endfunction

  function automatic longint rnd_clamp(longint acc);
    longint r;
    r = (acc + 128) >>> 8;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic model_add(input longint v);
    longint acc;
    xs[nx] = v;
    nx++;
    for (int ph = 0; ph < 2; ph++) begin
      acc = 0;
      for (int k = 0; k < 11; k++) acc += H[k] * ustuff(2*(nx-1) + ph - k);
      expv[ne] = rnd_clamp(acc);
      ne++;
    end
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic signed [15:0] v);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    model_add(v);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && ng < 1024) begin
      got[ng] = out_data;
      ng++;
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R3, R4, R6: vector table walked at maximum rate
    for (int r = 0; r < 18; r++) push(16'(TBL[r][0]));
    repeat (6) @(negedge clk);
    for (int r = 0; r < 18; r++) begin
      check(got[2*r] == 16'(TBL[r][1]), "R3/R6 filtered output", got[2*r], TBL[r][1]);
      check(got[2*r+1] == 16'(TBL[r][2]), "R4 delayed output", got[2*r+1], TBL[r][2]);
    end

    // R2: exact output timing for one isolated sample
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'sd300;
    model_add(300);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R2 no output after k", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 no output after k+1", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2 first output after k+2", out_valid, 1);
    @(negedge clk);
    check(out_valid == 1'b1, "R2 second output after k+3", out_valid, 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 idle after k+4", out_valid, 0);

    // R7: positive clamp
    push(16'sd32767); push(-16'sd32768); push(16'sd32767);
    push(16'sd32767); push(-16'sd32768);
    base = ne;
    push(16'sd32767);
    // R7: negative clamp
    push(-16'sd32768); push(16'sd32767); push(-16'sd32768);
    push(-16'sd32768); push(16'sd32767);
    push(-16'sd32768);
    repeat (6) @(negedge clk);
    check(got[base] == 16'sd32767, "R7 positive clamp", got[base], 32767);
    check(got[ne-2] == -16'sd32768, "R7 negative clamp", got[ne-2], -32768);

    // R5: data offered while blocked is ignored
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'sd5000;
    model_add(5000);
    @(negedge clk);
    check(in_ready == 1'b0, "R5 ready low after accept", in_ready, 0);
    in_data = -16'sd7777;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 5; i++) push(16'(i * 1111 - 2000));
    repeat (6) @(negedge clk);

    // R8: mixed ramp, with gaps and bursts
    for (int i = 0; i < 40; i++) begin
      push(16'((i * 3917) % 20000 - 10000));
      if (i % 7 == 3) repeat (3) @(negedge clk);
    end
    repeat (8) @(negedge clk);

    check(ng == ne, "R8 output count", ng, ne);
    for (int i = 0; i < ne && i < ng; i++)
      check(longint'(got[i]) == expv[i], "R8 stream vs reference", got[i], expv[i]);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule